// File: doc/BRIEF.md
# Data-Dependent Reference Index Unit

This unit serves a memory-hard hash engine that fills a matrix of blocks arranged as lanes (rows) and columns, with each row split into four equal segments called slices. A new block needs an earlier block as its second input. The unit picks that earlier block from the first 64 bits of the block just before it. It takes the coordinates of the block being built (pass number, lane, slice, position inside the segment), the lane count and column count, and that 64-bit word. It returns the lane and the absolute column of the block to read.

The upper 32 bits of the word choose the lane. The unit then works out how many blocks that lane may legally offer, given the slice and pass rules. The lower 32 bits are squared, and the result scales a position into that window, so that recently produced blocks are favoured. The position is counted from the oldest allowed block and then mapped back to an absolute column. Requests use a valid/ready handshake. The lane remainder is found one bit per cycle, so a request takes a few dozen cycles.

Top module: `ridx_unit`

## Requirements
- R1: `req_ready` is high only while the unit is idle. It falls in the cycle after a request is accepted and returns together with `resp_valid`. `resp_valid` is high for exactly one cycle per accepted request.
- R2: The reference lane is J2 mod `cfg_lanes`, where J2 = `req_prev[63:32]`. The full 32-bit J2 is used.
- R3: On the first pass (`req_pass` = 0) in slice 0, the reference lane is always the requesting lane, whatever J2 is.
- R4: With seg = `cfg_cols`/4, the window size is as follows. On the first pass, the base is slice·seg. On later passes, the base is `cfg_cols` − seg. For the requesting lane, the size is base + idx − 1. For any other lane, the size is base, minus 1 when idx = 0.
- R5: The window starts at column 0 on the first pass and when slice = 3. Otherwise it starts at (slice+1)·seg.
- R6: Let J1 = `req_prev[31:0]`, x = ⌊J1²/2³²⌋ and n the window size. The offset inside the window is n − 1 − ⌊n·x/2³²⌋, which always lies in 0..n−1.
- R7: `resp_col` = (start + offset) mod `cfg_cols`, so the column is always below `cfg_cols`.
- R8: J1 = 0 selects the newest allowed block (offset n−1). J1 = 0xFFFFFFFF selects the oldest (offset 0).
- R9: After synchronous reset, `resp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted when both high |
| req_pass | input | PASS_W | Pass number, 0 for the first |
| req_lane | input | LANE_W | Lane of the block being computed |
| req_slice | input | 2 | Slice 0..3 |
| req_idx | input | COL_W | Position inside the segment |
| cfg_lanes | input | LANE_W+1 | Lane count, 1..2^LANE_W |
| cfg_cols | input | COL_W | Columns per lane, a multiple of 4, at least 8 |
| req_prev | input | 64 | First 64 bits of the previous block |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_lane | output | LANE_W | Reference lane |
| resp_col | output | COL_W | Reference absolute column |

## Verification
The bench sweeps every legal position (pass 0 to 2, every lane, slice and index) in three small shapes: one lane with 12 columns, two lanes with 8, and three lanes with 16. Each position is tried with four previous-block words.

- A low half of zero and a low half of all ones pin the two ends of the skew (R8). A wrong sign or a dropped −1 moves them.
- Two scrambled low halves exercise the truncated multiplies in between.
- High halves carry large upper bits, so a remainder that drops bits differs from J2 mod p.
- The sweep crosses idx = 0 with same-lane and other-lane selections. This separates the exclusion rules of R4 and shows whether wrap happens on later passes.

// File: rtl/ridx_pkg.sv
`timescale 1ns/1ps
package ridx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MOD,
    ST_WIN,
    ST_SCALE,
    ST_OUT
  } ridx_state_t;

  localparam int SLICES   = 4;
  localparam int HALF_W   = 32;
endpackage

// File: rtl/ridx_lane_mod.sv
`timescale 1ns/1ps
// Sequential remainder: one numerator bit per cycle.
module ridx_lane_mod #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic [DEN_W-1:0] rem
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] sh_q;
  logic [DEN_W-1:0] rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEN_W-1:0] den_q;
  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   diff;
  logic             fits;

  always_comb begin
    trial = {rem_q, sh_q[NUM_W-1]};
    fits  = trial >= {1'b0, den_q};
    diff  = trial - {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      rem_q <= '0;
      cnt_q <= '0;
      den_q <= '0;
    end else if (start) begin
      sh_q  <= num;
      rem_q <= '0;
      den_q <= den;
      cnt_q <= CNT_W'(NUM_W);
    end else if (cnt_q != '0) begin
      sh_q  <= {sh_q[NUM_W-2:0], 1'b0};
      rem_q <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);
  assign rem  = rem_q;
endmodule

// File: rtl/ridx_window.sv
`timescale 1ns/1ps
// Size and start column of the allowed reference window.
module ridx_window #(
  parameter int COL_W = 24
) (
  input  logic             first_pass,
  input  logic [1:0]       slice,
  input  logic [COL_W-1:0] idx,
  input  logic             same_lane,
  input  logic [COL_W-1:0] seg,
  input  logic [COL_W-1:0] cols,
  output logic [COL_W-1:0] area,
  output logic [COL_W-1:0] start
);
  logic [COL_W-1:0] done_cols;
  logic [COL_W-1:0] base;

  always_comb begin
    case (slice)
      2'd0:    done_cols = '0;
      2'd1:    done_cols = seg;
      2'd2:    done_cols = seg << 1;
      default: done_cols = (seg << 1) + seg;
    endcase

    base = first_pass ? done_cols : (cols - seg);

    if (same_lane)
      area = base + idx - COL_W'(1);
    else if (idx == '0)
      area = base - COL_W'(1);
    else
      area = base;

    if (first_pass || slice == 2'd3)
      start = '0;
    else
      start = done_cols + seg;
  end
endmodule

// File: rtl/ridx_skew.sv
`timescale 1ns/1ps
// Maps squared fraction onto window: off = n-1 - floor(n*x / 2^32).
module ridx_skew #(
  parameter int COL_W = 24
) (
  input  logic [COL_W-1:0] area,
  input  logic [31:0]      frac,
  output logic [COL_W-1:0] off
);
  localparam int PROD_W = COL_W + 32;

  logic [PROD_W-1:0] prod;
  logic [COL_W-1:0]  hi;

  always_comb begin
    prod = PROD_W'(area) * PROD_W'(frac);
    hi   = prod[PROD_W-1:32];
    off  = area - COL_W'(1) - hi;
  end
endmodule

// File: rtl/ridx_unit.sv
`timescale 1ns/1ps
module ridx_unit #(
  parameter int PASS_W = 32,
  parameter int LANE_W = 6,
  parameter int COL_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PASS_W-1:0] req_pass,
  input  logic [LANE_W-1:0] req_lane,
  input  logic [1:0]        req_slice,
  input  logic [COL_W-1:0]  req_idx,
  input  logic [LANE_W:0]   cfg_lanes,
  input  logic [COL_W-1:0]  cfg_cols,
  input  logic [63:0]       req_prev,
  output logic              resp_valid,
  output logic [LANE_W-1:0] resp_lane,
  output logic [COL_W-1:0]  resp_col
);
  import ridx_pkg::*;

  localparam int P_W   = LANE_W + 1;
  localparam int SUM_W = COL_W + 1;

  ridx_state_t state_q;

  logic              first_r;
  logic [LANE_W-1:0] lane_r;
  logic [1:0]        slice_r;
  logic [COL_W-1:0]  idx_r;
  logic [COL_W-1:0]  q_r;
  logic [P_W-1:0]    p_r;
  logic [31:0]       j1_r;

  logic [LANE_W-1:0] ref_lane_r;
  logic [COL_W-1:0]  area_r;
  logic [COL_W-1:0]  start_r;
  logic [31:0]       sq_r;
  logic [COL_W-1:0]  off_r;

  logic              resp_valid_r;
  logic [LANE_W-1:0] resp_lane_r;
  logic [COL_W-1:0]  resp_col_r;

  logic              accept;
  logic              mod_busy;
  logic [P_W-1:0]    mod_rem;
  logic [LANE_W-1:0] lane_sel;
  logic              same_lane;
  logic [COL_W-1:0]  seg;
  logic [COL_W-1:0]  win_area;
  logic [COL_W-1:0]  win_start;
  logic [63:0]       sq_full;
  logic [COL_W-1:0]  skew_off;
  logic [SUM_W-1:0]  col_sum;
  logic [COL_W-1:0]  col_wrap;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  ridx_lane_mod #(.NUM_W(32), .DEN_W(P_W)) u_mod (
    .clk   (clk),
    .rst   (rst),
    .start (accept),
    .num   (req_prev[63:32]),
    .den   (cfg_lanes),
    .busy  (mod_busy),
    .rem   (mod_rem)
  );

  always_comb begin
    if (first_r && slice_r == 2'd0)
      lane_sel = lane_r;
    else
      lane_sel = mod_rem[LANE_W-1:0];
    same_lane = (lane_sel == lane_r);
    seg       = q_r >> 2;
    sq_full   = {32'b0, j1_r} * {32'b0, j1_r};
  end

  ridx_window #(.COL_W(COL_W)) u_win (
    .first_pass (first_r),
    .slice      (slice_r),
    .idx        (idx_r),
    .same_lane  (same_lane),
    .seg        (seg),
    .cols       (q_r),
    .area       (win_area),
    .start      (win_start)
  );

  ridx_skew #(.COL_W(COL_W)) u_skew (
    .area (area_r),
    .frac (sq_r),
    .off  (skew_off)
  );

  always_comb begin
    col_sum  = SUM_W'(start_r) + SUM_W'(off_r);
    col_wrap = (col_sum >= SUM_W'(q_r)) ? COL_W'(col_sum - SUM_W'(q_r))
                                        : col_sum[COL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      first_r      <= 1'b0;
      lane_r       <= '0;
      slice_r      <= '0;
      idx_r        <= '0;
      q_r          <= '0;
      p_r          <= '0;
      j1_r         <= '0;
      ref_lane_r   <= '0;
      area_r       <= '0;
      start_r      <= '0;
      sq_r         <= '0;
      off_r        <= '0;
      resp_valid_r <= 1'b0;
      resp_lane_r  <= '0;
      resp_col_r   <= '0;
    end else begin
      resp_valid_r <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            first_r <= (req_pass == '0);
            lane_r  <= req_lane;
            slice_r <= req_slice;
            idx_r   <= req_idx;
            q_r     <= cfg_cols;
            p_r     <= cfg_lanes;
            j1_r    <= req_prev[31:0];
            state_q <= ST_MOD;
          end
        end
        ST_MOD: begin
          if (!mod_busy) state_q <= ST_WIN;
        end
        ST_WIN: begin
          ref_lane_r <= lane_sel;
          area_r     <= win_area;
          start_r    <= win_start;
          sq_r       <= sq_full[63:32];
          state_q    <= ST_SCALE;
        end
        ST_SCALE: begin
          off_r   <= skew_off;
          state_q <= ST_OUT;
        end
        ST_OUT: begin
          resp_lane_r  <= ref_lane_r;
          resp_col_r   <= col_wrap;
          resp_valid_r <= 1'b1;
          state_q      <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign resp_valid = resp_valid_r;
  assign resp_lane  = resp_lane_r;
  assign resp_col   = resp_col_r;
endmodule

// File: rtl/ridx_unit_chk.sv
`timescale 1ns/1ps
module ridx_unit_chk #(
  parameter int LANE_W = 6,
  parameter int COL_W  = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic [LANE_W-1:0] resp_lane,
  input logic [COL_W-1:0]  resp_col,
  input logic [COL_W-1:0]  q_r,
  input logic [LANE_W:0]   p_r,
  input logic              first_r,
  input logic [1:0]        slice_r,
  input logic [LANE_W-1:0] lane_r,
  input logic [COL_W-1:0]  idx_r
);
  logic [COL_W+1:0] seg_w;
  logic [COL_W+1:0] cur_col;

  always_comb begin
    seg_w   = (COL_W+2)'(q_r >> 2);
    cur_col = seg_w * (COL_W+2)'(slice_r) + (COL_W+2)'(idx_r);
  end

  // R1
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);

  // R1
  resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  // R1
  resp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> req_ready);

  // R7
  col_range_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> resp_col < q_r);

  // R2
  lane_range_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> {1'b0, resp_lane} < p_r);

  // R3
  first_slice_lane_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid && first_r && slice_r == 2'd0 |-> resp_lane == lane_r);

  // R4
  no_prev_block_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid && first_r && resp_lane == lane_r
      |-> (COL_W+2)'(resp_col) + 2 <= cur_col);
endmodule

bind ridx_unit ridx_unit_chk #(.LANE_W(LANE_W), .COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .resp_lane  (resp_lane),
  .resp_col   (resp_col),
  .q_r        (q_r),
  .p_r        (p_r),
  .first_r    (first_r),
  .slice_r    (slice_r),
  .lane_r     (lane_r),
  .idx_r      (idx_r)
);

// File: tb/tb_ridx_unit.sv
`timescale 1ns/1ps
module tb_ridx_unit;
  localparam int PASS_W = 32;
  localparam int LANE_W = 6;
  localparam int COL_W  = 24;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [PASS_W-1:0] req_pass = '0;
  logic [LANE_W-1:0] req_lane = '0;
  logic [1:0]        req_slice = '0;
  logic [COL_W-1:0]  req_idx = '0;
  logic [LANE_W:0]   cfg_lanes = 7'd1;
  logic [COL_W-1:0]  cfg_cols = 24'd8;
  logic [63:0]       req_prev = '0;
  logic              resp_valid;
  logic [LANE_W-1:0] resp_lane;
  logic [COL_W-1:0]  resp_col;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  ridx_unit #(.PASS_W(PASS_W), .LANE_W(LANE_W), .COL_W(COL_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_pass(req_pass), .req_lane(req_lane), .req_slice(req_slice),
    .req_idx(req_idx), .cfg_lanes(cfg_lanes), .cfg_cols(cfg_cols),
    .req_prev(req_prev), .resp_valid(resp_valid), .resp_lane(resp_lane),
    .resp_col(resp_col)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL R1 watchdog expired: actual %0d cycles expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_req(input int pss, input int ln, input int sl, input int ix,
                         input int p, input int q, input logic [63:0] jv, input bit edge_case);
    int seg, base, area, start, exp_lane, exp_col, n;
    logic [63:0] j1, x, y;
    logic [31:0] j2;
    seg = q / 4;
    j2  = jv[63:32];
    j1  = {32'b0, jv[31:0]};
    exp_lane = (pss == 0 && sl == 0) ? ln : int'(j2 % 32'(p));
    base = (pss == 0) ? sl * seg : q - seg;
    if (exp_lane == ln) area = base + ix - 1;
    else area = base - ((ix == 0) ? 1 : 0);
    start = (pss == 0 || sl == 3) ? 0 : (sl + 1) * seg;
    x = (j1 * j1) >> 32;
    y = (64'(area) * x) >> 32;
    exp_col = (start + area - 1 - int'(y)) % q;

    @(negedge clk);
    req_pass  = PASS_W'(pss);
    req_lane  = LANE_W'(ln);
    req_slice = 2'(sl);
    req_idx   = COL_W'(ix);
    cfg_lanes = 7'(p);
    cfg_cols  = COL_W'(q);
    req_prev  = jv;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R1 ready low while busy", longint'(req_ready), 0);
    n = 0;
    while (!resp_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(resp_valid == 1'b1, "R1 response arrives", longint'(resp_valid), 1);
    if (pss == 0 && sl == 0)
      check(int'(resp_lane) == exp_lane, "R3 lane forced to own lane", longint'(resp_lane), exp_lane);
    else
      check(int'(resp_lane) == exp_lane, "R2 lane from J2 mod p", longint'(resp_lane), exp_lane);
    if (edge_case)
      check(int'(resp_col) == exp_col, "R8 skew end point column", longint'(resp_col), exp_col);
    else
      check(int'(resp_col) == exp_col, "R4/R5/R6/R7 reference column", longint'(resp_col), exp_col);
    check(req_ready == 1'b1, "R1 ready back with response", longint'(req_ready), 1);
    @(negedge clk);
    check(resp_valid == 1'b0, "R1 single cycle strobe", longint'(resp_valid), 0);
  endtask

  initial begin
    int cp [3] = '{1, 2, 3};
    int cq [3] = '{12, 8, 16};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(resp_valid == 1'b0, "R9 reset resp_valid", longint'(resp_valid), 0);
    check(req_ready == 1'b1, "R9 reset req_ready", longint'(req_ready), 1);

    for (int c = 0; c < 3; c++) begin
      for (int pss = 0; pss < 3; pss++) begin
        for (int ln = 0; ln < cp[c]; ln++) begin
          for (int sl = 0; sl < 4; sl++) begin
            for (int ix = 0; ix < cq[c] / 4; ix++) begin
              if (pss == 0 && sl == 0 && ix < 2) continue;
              for (int k = 0; k < 4; k++) begin
                logic [31:0] hi, lo;
                hi = 32'(ix * 7 + sl * 3 + pss * 5 + ln + k) + 32'h4000_0000 * 32'(k);
                case (k)
                  0: lo = 32'h0000_0000;
                  1: lo = 32'hFFFF_FFFF;
                  2: lo = 32'h9E37_79B9 ^ 32'(ix * 32'h0101_0101 + sl * 977);
                  default: lo = 32'h7F4A_7C15 + 32'(pss * 32'h1234_567 + ln * 31 + ix);
                endcase
                run_req(pss, ln, sl, ix, cp[c], cq[c], {hi, lo}, k < 2);
              end
            end
          end
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule